// File: doc/BRIEF.md
# Token-Based Lock Sequencer

This block limits how many receive channels may try to acquire clock-data-recovery lock at the same time. Each attempt draws more power than a locked channel, so capping the number of concurrent attempts caps the peak supply current. A shared pool holds a configurable number of tokens. A channel with a valid input signal, permission to attempt lock and an active request joins a wait line. Free tokens go to the channels in the order in which they joined the line.

A token comes back to the pool when its holder reports lock, or when the holder loses its input signal before locking. A channel that loses its signal, its permission or its request while it is still waiting leaves the line. If it becomes eligible again, it rejoins at the back. The grant output of a channel stays high for as long as that channel holds a token. The recovery loop itself is outside this block.

Top module: `lock_token_seq`

## Requirements
- R1: A grant is issued only to a channel whose signal-detect input is high.
- R2: A grant is issued only to a channel whose permit input is high. A waiting channel whose permit, request or signal detect goes low leaves the wait line.
- R3: When a holder reports lock, its grant falls at the next clock edge, and at that same edge the freed token may go to the next waiting channel.
- R4: Waiting channels receive tokens in the order in which they became eligible, whatever their channel indices.
- R5: Channels that become eligible in the same cycle are ordered by channel index, lowest index first.
- R6: At the moment any grant is issued, the number of channels holding grants does not exceed the token limit.
- R7: A holder whose signal detect goes low before it locks loses its grant at the next clock edge, and its token returns to the pool.
- R8: The token limit is a 5-bit input clamped to the range 1 to 16: a value of 0 acts as 1 and any value above 16 acts as 16. Lowering the limit does not revoke grants already made; new grants wait until the number of holders falls below the new limit.
- R9: A waiting channel whose signal detect drops loses its place in line. When it becomes eligible again it goes behind every channel that is already waiting.
- R10: A channel that becomes eligible while a token is free sees its grant rise at the second clock edge after its inputs are applied, and not at the first.
- R11: While the synchronous active-low reset is applied, every grant is low and the wait line is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_det | input | NUM_CH | Per-channel valid-input-signal indication |
| lock_permit | input | NUM_CH | Per-channel permission to attempt lock |
| lock_req | input | NUM_CH | Per-channel request for a token |
| cdr_locked | input | NUM_CH | Per-channel lock-achieved indication |
| tok_limit | input | LIM_W (5) | Number of tokens in the pool, clamped to 1..MAX_TOK |
| grant | output | NUM_CH | Per-channel token-held indication |

## Verification
A corrupted arrival-order record shows up at the grant port as a token given to the wrong channel. This appears at the first edge at which a token is freed while two or more channels wait, so the ordering tests release tokens one at a time and check which single grant bit rises. A miscounted pool shows up at the same edge as either an extra grant or a missing grant. Stale wait-line membership shows up when a channel that has dropped out and rejoined is granted ahead of a channel that joined before it. The bench drives each of these cases and checks the grant port one cycle after each release.

// File: rtl/lts_pkg.sv
// Package: shared helpers for the lock token sequencer.
// Assumes no channel vector is wider than 32 bits.
package lts_pkg;

    // Counts the set bits in a vector of up to 32 bits.
    function automatic int count_ones(input logic [31:0] v);
        int n;
        n = 0;
        for (int b = 0; b < 32; b++) begin
            n += int'(v[b]);
        end
        return n;
    endfunction

endpackage

// File: rtl/lts_token_pool.sv
// Module: lts_token_pool
// Clamps the programmed token limit to 1..MAX_TOK and computes how many
// tokens are free, given the set of channels that keep their token this cycle.
// Assumes NUM_CH <= 32. Purely combinational.
module lts_token_pool #(
    parameter int NUM_CH  = 8,
    parameter int MAX_TOK = 16,
    parameter int LIM_W   = 5,
    parameter int CW      = 5
) (
    input  logic [NUM_CH-1:0] kept,
    input  logic [LIM_W-1:0]  tok_limit,
    output logic [CW-1:0]     free_tok,
    output logic [CW-1:0]     eff_limit
);
    import lts_pkg::*;

    logic [CW-1:0] held;

    // Clamp the limit and subtract the tokens that stay held.
    always_comb begin
        if (tok_limit == '0) begin
            eff_limit = CW'(1);
        end else if (int'(tok_limit) > MAX_TOK) begin
            eff_limit = CW'(MAX_TOK);
        end else begin
            eff_limit = CW'(tok_limit);
        end
        held     = CW'(count_ones(32'(kept)));
        free_tok = (eff_limit > held) ? (eff_limit - held) : '0;
    end

endmodule

// File: rtl/lts_age_order.sv
// Module: lts_age_order
// Records the arrival order of waiting channels in a matrix: row k, bit j set
// means channel j arrived before channel k. Outputs the rank of each candidate,
// which is the number of older candidates. Channels that arrive in the same
// cycle are ordered by index, lowest first. Assumes NUM_CH <= 32.
module lts_age_order #(
    parameter int NUM_CH = 8,
    parameter int CW     = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              in_line,
    input  logic [NUM_CH-1:0]              joining,
    input  logic [NUM_CH-1:0]              cand,
    output logic [NUM_CH-1:0][CW-1:0]      rank
);
    import lts_pkg::*;

    logic [NUM_CH-1:0][NUM_CH-1:0] ahead_q, ahead_d;

    // Next-state rows: a joiner sees everything already in line as older;
    // a joiner's column is cleared in every other row.
    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            for (int j = 0; j < NUM_CH; j++) begin
                if (joining[k]) begin
                    ahead_d[k][j] = in_line[j] | (joining[j] && (j < k));
                end else begin
                    ahead_d[k][j] = ahead_q[k][j] & ~joining[j];
                end
            end
        end
    end

    // Register the order matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ahead_q <= '0;
        end else begin
            ahead_q <= ahead_d;
        end
    end

    // Rank of each channel among the current candidates.
    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            rank[k] = CW'(count_ones(32'(ahead_q[k] & cand)));
        end
    end

    // R11: the order record is empty after reset.
    assert_order_cleared_R11: assert property (@(posedge clk)
        $past(!rst_n) |-> (ahead_q == '0));

endmodule

// File: rtl/lock_token_seq.sv
// Module: lock_token_seq (top)
// Grants lock-attempt tokens to eligible channels in arrival order, takes a
// token back when its holder locks or loses its signal, and never lets the
// number of holders exceed the programmed limit at the moment of a grant.
// Assumes NUM_CH <= 32 and all inputs synchronous to clk.
module lock_token_seq #(
    parameter int NUM_CH  = 8,
    parameter int MAX_TOK = 16,
    parameter int LIM_W   = $clog2(MAX_TOK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sig_det,
    input  logic [NUM_CH-1:0] lock_permit,
    input  logic [NUM_CH-1:0] lock_req,
    input  logic [NUM_CH-1:0] cdr_locked,
    input  logic [LIM_W-1:0]  tok_limit,
    output logic [NUM_CH-1:0] grant
);
    localparam int BIGGEST = (NUM_CH > MAX_TOK) ? NUM_CH : MAX_TOK;
    localparam int CW      = $clog2(BIGGEST + 1);

    logic [NUM_CH-1:0]         grant_q, wait_q;
    logic [NUM_CH-1:0]         eligible, release_c, stay_wait, joining, issue;
    logic [NUM_CH-1:0]         kept;
    logic [NUM_CH-1:0][CW-1:0] rank;
    logic [CW-1:0]             free_tok, eff_limit;

    // Per-channel eligibility, token return and wait-line membership.
    always_comb begin
        eligible  = lock_req & sig_det & lock_permit & ~cdr_locked;
        release_c = grant_q & (cdr_locked | ~sig_det);
        kept      = grant_q & ~release_c;
        stay_wait = wait_q & eligible;
        joining   = eligible & ~wait_q & ~grant_q;
    end

    lts_token_pool #(
        .NUM_CH (NUM_CH),
        .MAX_TOK(MAX_TOK),
        .LIM_W  (LIM_W),
        .CW     (CW)
    ) u_pool (
        .kept     (kept),
        .tok_limit(tok_limit),
        .free_tok (free_tok),
        .eff_limit(eff_limit)
    );

    lts_age_order #(
        .NUM_CH(NUM_CH),
        .CW    (CW)
    ) u_order (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_line(wait_q),
        .joining(joining),
        .cand   (stay_wait),
        .rank   (rank)
    );

    // Hand free tokens to the oldest candidates.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            issue[i] = stay_wait[i] && (rank[i] < free_tok);
        end
    end

    // Register grants and wait-line membership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            wait_q  <= '0;
        end else begin
            grant_q <= kept | issue;
            wait_q  <= (stay_wait & ~issue) | joining;
        end
    end

    assign grant = grant_q;

    // R6: the pool never hands out more tokens than the limit.
    assert_cap_at_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant_q & ~$past(grant_q))) |-> ($countones(grant_q) <= int'($past(eff_limit))));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            // R1, R2: a new grant needs signal detect and permit in the prior cycle.
            assert_grant_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(grant_q[c]) |-> $past(sig_det[c] && lock_permit[c]));
            // R3: lock returns the token at the next edge.
            assert_lock_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_q[c] && cdr_locked[c]) |=> !grant_q[c]);
            // R7: losing signal detect returns the token at the next edge.
            assert_sigloss_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_q[c] && !sig_det[c]) |=> !grant_q[c]);
            // R9: a channel is never both waiting and holding.
            assert_wait_or_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !(grant_q[c] && wait_q[c]));
        end
    endgenerate

endmodule

// File: tb/lock_token_seq_tb.sv
// Directed bench for lock_token_seq: one task per scenario.
module lock_token_seq_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] sig_det, lock_permit, lock_req, cdr_locked;
    logic [4:0]   tok_limit;
    logic [N-1:0] grant;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    lock_token_seq #(.NUM_CH(N), .MAX_TOK(16)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_det    (sig_det),
        .lock_permit(lock_permit),
        .lock_req   (lock_req),
        .cdr_locked (cdr_locked),
        .tok_limit  (tok_limit),
        .grant      (grant)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s grant actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [4:0] lim);
        rst_n = 1'b0;
        sig_det = '0; lock_permit = '0; lock_req = '0; cdr_locked = '0;
        tok_limit = lim;
        step(2);
        rst_n = 1'b1;
    endtask

    // R11: nothing granted straight out of reset, even with requests pending.
    task automatic t_reset();
        do_reset(5'd4);
        rst_n = 1'b0;
        sig_det = '1; lock_permit = '1; lock_req = '1;
        step(2);
        chk("R11 reset", grant, 8'h00);
        rst_n = 1'b1;
    endtask

    // R1, R2, R10: gating and request-to-grant latency.
    task automatic t_gating();
        do_reset(5'd4);
        lock_req = 8'hFF; sig_det = 8'h0F; lock_permit = 8'hFD;
        step(1);
        chk("R10 not after one edge", grant, 8'h00);
        step(1);
        chk("R1 R2 gated grants", grant, 8'h0D);
    endtask

    // R5, R3, R6: same-cycle tie by index, lock returns token, cap kept.
    task automatic t_tie_and_lock();
        do_reset(5'd2);
        lock_req = 8'hFF; sig_det = 8'hFF; lock_permit = 8'hFF;
        step(2);
        chk("R5 R6 lowest two", grant, 8'h03);
        cdr_locked[0] = 1'b1;
        step(1);
        chk("R3 token moves to ch2", grant, 8'h06);
        step(1);
        chk("R6 no extra grant", grant, 8'h06);
    endtask

    // R4: arrival order beats index order.
    task automatic t_fcfs();
        do_reset(5'd1);
        sig_det = 8'hFF; lock_permit = 8'hFF;
        lock_req[5] = 1'b1;
        step(1);
        lock_req[6] = 1'b1;
        step(1);
        chk("R4 first arrival granted", grant, 8'h20);
        lock_req[1] = 1'b1;
        step(1);
        cdr_locked[5] = 1'b1;
        step(1);
        chk("R4 second arrival next", grant, 8'h40);
        cdr_locked[6] = 1'b1;
        step(1);
        chk("R4 low index last", grant, 8'h02);
    endtask

    // R7: holder losing signal gives its token away.
    task automatic t_sigloss();
        do_reset(5'd1);
        sig_det = 8'hFF; lock_permit = 8'hFF;
        lock_req = 8'h18;
        step(2);
        chk("R7 ch3 holds", grant, 8'h08);
        sig_det[3] = 1'b0;
        step(1);
        chk("R7 token to ch4", grant, 8'h10);
    endtask

    // R9: a waiter that drops out rejoins at the back.
    task automatic t_requeue();
        do_reset(5'd1);
        sig_det = 8'hFF; lock_permit = 8'hFF;
        lock_req[0] = 1'b1;
        step(1);
        lock_req[1] = 1'b1;
        step(1);
        lock_req[2] = 1'b1;
        step(1);
        sig_det[1] = 1'b0;
        step(1);
        chk("R9 waiter with no signal not granted", grant, 8'h01);
        sig_det[1] = 1'b1;
        step(1);
        cdr_locked[0] = 1'b1;
        step(1);
        chk("R9 later arrival passes rejoined ch1", grant, 8'h04);
        cdr_locked[2] = 1'b1;
        step(1);
        chk("R9 rejoined ch1 served last", grant, 8'h02);
    endtask

    // R8: limit changes, clamping, no revocation.
    task automatic t_limit();
        do_reset(5'd3);
        sig_det = 8'hFF; lock_permit = 8'hFF; lock_req = 8'hFF;
        step(2);
        chk("R8 three holders", grant, 8'h07);
        tok_limit = 5'd1;
        step(1);
        chk("R8 no revoke on lower limit", grant, 8'h07);
        cdr_locked[0] = 1'b1;
        step(1);
        chk("R8 no new grant above limit", grant, 8'h06);
        cdr_locked[2:1] = 2'b11;
        step(1);
        chk("R8 grant when below limit", grant, 8'h08);
        tok_limit = 5'd0;
        cdr_locked[3] = 1'b1;
        step(1);
        chk("R8 zero acts as one", grant, 8'h10);
        tok_limit = 5'd31;
        step(1);
        chk("R8 large value clamps high", grant, 8'hF0);
    endtask

    initial begin
        t_reset();
        t_gating();
        t_tie_and_lock();
        t_fcfs();
        t_sigloss();
        t_requeue();
        t_limit();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule